// File: doc/BRIEF.md
# Packed Signed Greater-Than Compare Unit

This execution unit takes two packed operands, a destination and a source, and compares them lane by lane as signed integers. Every lane where the destination element is strictly larger than the source element becomes all ones. Every other lane becomes all zeros. An opcode byte selects the lane size at run time. A mode bit selects the operand width: the narrow mode uses the low 64 bits and the wide mode uses all 128 bits.

The unit also performs two checks before it writes a result. The first rejects an opcode that is not one of the three compare encodings. The second rejects a wide operation whose source comes from memory at an address that is not aligned to 16 bytes. In both cases the result is suppressed and a fault flag is raised. The valid strobe is still issued, so the surrounding pipeline stays in step.

The unit accepts one operation per cycle. Each result appears two cycles after its inputs are presented. The unit drives no status flags.

Top module: `simd_gt_cmp`

## Requirements
- R1: The opcode byte selects the lane size: 8'h64 gives 8-bit lanes, 8'h65 gives 16-bit lanes and 8'h66 gives 32-bit lanes.
- R2: Each lane is compared as a two's-complement signed value. A lane is true only when the destination element is strictly greater than the source element, so equal elements give false.
- R3: A true lane is written as all ones across its full width, and a false lane is written as all zeros.
- R4: When wide_i is 0, only bits 63:0 are compared and result bits 127:64 are 0. When wide_i is 1, bits 127:0 are compared.
- R5: When wide_i=1 and mem_src_i=1 and addr_ofs_i (the low four address bits) is nonzero, gp_fault_o is raised and result_o is 0. No alignment fault is raised when wide_i=0 or when mem_src_i=0.
- R6: Any opcode other than 8'h64, 8'h65 or 8'h66 raises ud_fault_o with result_o 0, and valid_o is still issued. An illegal opcode never also raises gp_fault_o.
- R7: An operation presented with valid_i in cycle n gives valid_o and its result in cycle n+2. Operations may be presented back to back, one every cycle.
- R8: While rst_ni is low, valid_o, gp_fault_o and ud_fault_o are 0 and result_o is 0.
- R9: In a cycle where valid_o is 0, result_o, gp_fault_o and ud_fault_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| opcode_i | input | 8 | Compare opcode that selects the lane size |
| wide_i | input | 1 | 1 selects 128-bit operation, 0 selects 64-bit operation |
| mem_src_i | input | 1 | The source operand comes from memory |
| addr_ofs_i | input | 4 | Low bits of the source address, used for the alignment check |
| dst_i | input | 128 | Destination operand |
| src_i | input | 128 | Source operand |
| valid_o | output | 1 | A result is present this cycle |
| result_o | output | 128 | Per-lane mask |
| gp_fault_o | output | 1 | Misaligned wide memory source |
| ud_fault_o | output | 1 | Illegal opcode |

## Verification
A wrong internal state would reach the ports two cycles after the operation that caused it. The ways it shows up are:
- A lane-size decode error gives a mask whose runs of ones have the wrong length or the wrong boundaries.
- A lost sign gives the wrong answer when the most negative element is compared with the most positive one.
- A stale narrow-mode flag leaks ones into bits 127:64.
- A misrouted fault flag gives a nonzero result alongside a fault, or a missing fault on a misaligned wide memory source.

Every result is compared in full against a model, so any such error is reported in the cycle it reaches the outputs.

// File: rtl/simd_gt_pkg.sv
`timescale 1ns/1ps
package simd_gt_pkg;
  typedef enum logic [1:0] {
    LANE_8   = 2'd0,
    LANE_16  = 2'd1,
    LANE_32  = 2'd2,
    LANE_BAD = 2'd3
  } lane_e;

  localparam logic [7:0] OPC_GT8  = 8'h64;
  localparam logic [7:0] OPC_GT16 = 8'h65;
  localparam logic [7:0] OPC_GT32 = 8'h66;
endpackage

// File: rtl/simd_gt_decode.sv
`timescale 1ns/1ps
module simd_gt_decode
  import simd_gt_pkg::*;
(
  input  logic [7:0] opcode_i,
  output lane_e      lane_o,
  output logic       illegal_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_GT8:  lane_o = LANE_8;
      OPC_GT16: lane_o = LANE_16;
      OPC_GT32: lane_o = LANE_32;
      default:  lane_o = LANE_BAD;
    endcase
    illegal_o = (lane_o == LANE_BAD);
  end
endmodule

// File: rtl/simd_gt_lanes.sv
`timescale 1ns/1ps
module simd_gt_lanes
  import simd_gt_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  lane_e             lane_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int N_SIZES = 3;

  logic [N_SIZES-1:0][DATA_W-1:0] gt;

  // one mask per lane size; k=0 is 8-bit, 1 is 16-bit, 2 is 32-bit
  for (genvar k = 0; k < N_SIZES; k++) begin : g_size
    localparam int LW = 8 << k;
    localparam int NL = DATA_W / LW;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      assign gt[k][j*LW +: LW] =
        {LW{$signed(dst_i[j*LW +: LW]) > $signed(src_i[j*LW +: LW])}};
    end
  end

  always_comb begin
    unique case (lane_i)
      LANE_8:  mask_o = gt[0];
      LANE_16: mask_o = gt[1];
      LANE_32: mask_o = gt[2];
      default: mask_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_gt_cmp.sv
`timescale 1ns/1ps
module simd_gt_cmp
  import simd_gt_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int OFS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic              wide_i,
  input  logic              mem_src_i,
  input  logic [OFS_W-1:0]  addr_ofs_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              gp_fault_o,
  output logic              ud_fault_o
);
  localparam int HALF_W = DATA_W / 2;

  lane_e lane_d;
  logic  ill_d;
  logic  gp_d;

  simd_gt_decode i_decode (
    .opcode_i  (opcode_i),
    .lane_o    (lane_d),
    .illegal_o (ill_d)
  );

  // illegal opcode outranks the alignment fault
  assign gp_d = wide_i & mem_src_i & (|addr_ofs_i) & ~ill_d;

  // stage 1: capture
  logic              v1_q, ill1_q, gp1_q, wide1_q;
  lane_e             lane1_q;
  logic [DATA_W-1:0] dst1_q, src1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      ill1_q  <= 1'b0;
      gp1_q   <= 1'b0;
      wide1_q <= 1'b0;
      lane1_q <= LANE_BAD;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        ill1_q  <= ill_d;
        gp1_q   <= gp_d;
        wide1_q <= wide_i;
        lane1_q <= lane_d;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      dst1_q <= dst_i;
      src1_q <= src_i;
    end
  end

  // stage 2: compare, narrow masking, write
  logic [DATA_W-1:0] mask_raw, mask_s;

  simd_gt_lanes #(.DATA_W(DATA_W)) i_lanes (
    .dst_i  (dst1_q),
    .src_i  (src1_q),
    .lane_i (lane1_q),
    .mask_o (mask_raw)
  );

  always_comb begin
    mask_s = mask_raw;
    if (!wide1_q) mask_s[DATA_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      gp_fault_o <= 1'b0;
      ud_fault_o <= 1'b0;
    end else begin
      valid_o    <= v1_q;
      gp_fault_o <= v1_q & gp1_q;
      ud_fault_o <= v1_q & ill1_q;
      result_o   <= (v1_q && !ill1_q && !gp1_q) ? mask_s : '0;
    end
  end
endmodule

// File: rtl/simd_gt_cmp_chk.sv
`timescale 1ns/1ps
module simd_gt_cmp_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        opcode_i,
  input logic              wide_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              gp_fault_o,
  input logic              ud_fault_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NB     = DATA_W / 8;

  logic v_d1, v_d2, n_d1, n_d2, bad_d1, bad_d2;
  logic bad_now;

  assign bad_now = !(opcode_i inside {8'h64, 8'h65, 8'h66});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_d1 <= 1'b0; v_d2 <= 1'b0;
      n_d1 <= 1'b0; n_d2 <= 1'b0;
      bad_d1 <= 1'b0; bad_d2 <= 1'b0;
    end else begin
      v_d1   <= valid_i;
      v_d2   <= v_d1;
      n_d1   <= valid_i & ~wide_i;
      n_d2   <= n_d1;
      bad_d1 <= valid_i & bad_now;
      bad_d2 <= bad_d1;
    end
  end

  function automatic logic bytes_uniform(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < NB; b++)
      if (v[b*8 +: 8] != 8'h00 && v[b*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  AST_LATENCY_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_d2); // R7

  AST_MASK_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bytes_uniform(result_o)); // R3

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_d2 |-> result_o[DATA_W-1:HALF_W] == '0); // R4

  AST_FAULT_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |-> result_o == '0); // R5

  AST_UD_TRACKS_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_fault_o == bad_d2); // R6

  AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gp_fault_o && ud_fault_o)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0 && !gp_fault_o && !ud_fault_o)); // R9
endmodule

bind simd_gt_cmp simd_gt_cmp_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .opcode_i   (opcode_i),
  .wide_i     (wide_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .gp_fault_o (gp_fault_o),
  .ud_fault_o (ud_fault_o)
);

// File: tb/test_simd_gt_cmp.sv
`timescale 1ns/1ps
module test_simd_gt_cmp;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [7:0]   opcode_i = 8'h64;
  logic         wide_i = 1'b0;
  logic         mem_src_i = 1'b0;
  logic [3:0]   addr_ofs_i = '0;
  logic [127:0] dst_i = '0;
  logic [127:0] src_i = '0;
  logic         valid_o;
  logic [127:0] result_o;
  logic         gp_fault_o;
  logic         ud_fault_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_gt_cmp i_simd_gt_cmp (.*);

  typedef struct {
    logic         v;
    logic [127:0] res;
    logic         gp;
    logic         ud;
    string        tag;
  } exp_t;

  exp_t e1, e2;

  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] s,
                                         input logic [7:0] op, input logic wide);
    logic [127:0] r;
    r = '0;
    case (op)
      8'h64: for (int i = 0; i < 16; i++)
               r[i*8 +: 8] = ($signed(d[i*8 +: 8]) > $signed(s[i*8 +: 8])) ? 8'hFF : 8'h00;
      8'h65: for (int i = 0; i < 8; i++)
               r[i*16 +: 16] = ($signed(d[i*16 +: 16]) > $signed(s[i*16 +: 16])) ? 16'hFFFF : 16'h0;
      8'h66: for (int i = 0; i < 4; i++)
               r[i*32 +: 32] = ($signed(d[i*32 +: 32]) > $signed(s[i*32 +: 32])) ? 32'hFFFF_FFFF : 32'h0;
      default: r = '0;
    endcase
    if (!wide) r[127:64] = '0;
    return r;
  endfunction

  task automatic check_out(input exp_t e);
    checks++;
    if (valid_o !== e.v || result_o !== e.res || gp_fault_o !== e.gp || ud_fault_o !== e.ud) begin
      errors++;
      $display("FAIL %s: got v=%0b res=%h gp=%0b ud=%0b, expected v=%0b res=%h gp=%0b ud=%0b",
               e.tag, valid_o, result_o, gp_fault_o, ud_fault_o, e.v, e.res, e.gp, e.ud);
    end
  endtask

  // at a falling edge: check the op from two cycles back, then present a new one
  task automatic issue(input logic v, input logic [7:0] op, input logic w, input logic m,
                       input logic [3:0] a, input logic [127:0] d, input logic [127:0] s,
                       input string tag);
    exp_t n;
    logic ill, gp;
    @(negedge clk_i);
    check_out(e2);
    ill = !(op == 8'h64 || op == 8'h65 || op == 8'h66);
    gp  = w && m && (a != 4'h0) && !ill;
    n.v   = v;
    n.ud  = v && ill;
    n.gp  = v && gp;
    n.res = (v && !ill && !gp) ? model(d, s, op, w) : '0;
    n.tag = v ? tag : "R9 idle";
    e2 = e1;
    e1 = n;
    valid_i = v; opcode_i = op; wide_i = w; mem_src_i = m;
    addr_ofs_i = a; dst_i = d; src_i = s;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t idle;
    logic [7:0] op;
    void'($urandom(32'h5eed_1234));
    idle.v = 0; idle.res = '0; idle.gp = 0; idle.ud = 0; idle.tag = "R9 idle";
    e1 = idle; e2 = idle;
    idle.tag = "R8 reset";
    // R8: hold reset with an operation presented
    valid_i = 1'b1; dst_i = '1; src_i = '0;
    repeat (4) begin
      @(negedge clk_i);
      check_out(idle);
    end
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 equal values give zero; R3 mask width per lane size (R1)
    issue(1, 8'h64, 1, 0, 0, {16{8'h5A}}, {16{8'h5A}}, "R2 equal bytes");
    issue(1, 8'h65, 1, 0, 0, {8{16'h1234}}, {8{16'h1234}}, "R2 equal words");
    issue(1, 8'h66, 1, 0, 0, {4{32'hDEADBEEF}}, {4{32'hDEADBEEF}}, "R2 equal dwords");
    // R2 most-negative versus most-positive, both directions
    issue(1, 8'h64, 1, 0, 0, {8{8'h80, 8'h7F}}, {8{8'h7F, 8'h80}}, "R2 byte extremes");
    issue(1, 8'h65, 1, 0, 0, {4{16'h8000, 16'h7FFF}}, {4{16'h7FFF, 16'h8000}}, "R2 word extremes");
    issue(1, 8'h66, 1, 0, 0, {2{32'h8000_0000, 32'h7FFF_FFFF}}, {2{32'h7FFF_FFFF, 32'h8000_0000}}, "R2 dword extremes");
    // R1 lane size: same data, three sizes (low byte larger, high byte smaller)
    issue(1, 8'h64, 1, 0, 0, {8{16'h0102}}, {8{16'h0201}}, "R1 8-bit lanes");
    issue(1, 8'h65, 1, 0, 0, {8{16'h0102}}, {8{16'h0201}}, "R1 16-bit lanes");
    issue(1, 8'h66, 1, 0, 0, {4{32'h0001_FFFF}}, {4{32'h0000_0001}}, "R1 32-bit lanes");
    // R4 narrow mode ignores upper half
    issue(1, 8'h64, 0, 0, 0, '1 >> 1, '0, "R4 narrow bytes");
    issue(1, 8'h66, 0, 1, 4'h4, {{2{32'h1}}, {2{32'h0}}}, {{2{32'h0}}, {2{32'h1}}}, "R4 narrow dwords");
    // R5 alignment
    issue(1, 8'h64, 1, 1, 4'h8, {16{8'h10}}, '0, "R5 misaligned wide mem");
    issue(1, 8'h65, 1, 1, 4'h1, {8{16'h10}}, '0, "R5 misaligned wide mem");
    issue(1, 8'h66, 1, 1, 4'h0, {4{32'h10}}, '0, "R5 aligned wide mem");
    issue(1, 8'h64, 1, 0, 4'hF, {16{8'h10}}, '0, "R5 register source no check");
    issue(1, 8'h64, 0, 1, 4'h3, {16{8'h10}}, '0, "R5 narrow mem no check");
    // R6 illegal opcodes, including misaligned
    issue(1, 8'h63, 1, 0, 0, '1, '0, "R6 illegal 63");
    issue(1, 8'h67, 1, 1, 4'h2, '1, '0, "R6 illegal 67 misaligned");
    issue(1, 8'h00, 0, 0, 0, '1, '0, "R6 illegal 00");
    // R9 idle gap, then R7 back-to-back
    issue(0, 8'h64, 1, 0, 0, '1, '0, "R9 idle");
    issue(0, 8'h64, 1, 0, 0, '1, '0, "R9 idle");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] pick;
      logic [3:0] a;
      pick = 2'($urandom_range(0, 3));
      op = (pick == 2'd3) ? 8'($urandom) : 8'h64 + 8'(pick);
      a = ($urandom_range(0, 1) == 0) ? 4'h0 : 4'($urandom);
      issue(1'($urandom_range(0, 7) != 0), op, 1'($urandom), 1'($urandom), a,
            rnd128(), rnd128(), "R7 random stream");
    end
    issue(0, 8'h64, 0, 0, 0, '0, '0, "R9 idle");
    issue(0, 8'h64, 0, 0, 0, '0, '0, "R9 idle");
    issue(0, 8'h64, 0, 0, 0, '0, '0, "R9 idle");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule